// File: doc/BRIEF.md
# Host Bus Takeover Controller

This block lets a supervisor take the external bus of a host processor away from it. It keeps the host in one of four conditions: held in reset, held in reset with the bus handed over, running, or running with the bus handed over. It drives an active-low reset and an active-low bus-request line, and it samples the host's active-low bus-acknowledge through a synchronizer. It also drives the enables that either drive or float the address lines and the read, write and memory-request strobes.

The supervisor issues one-cycle commands on `cmd` qualified by `cmd_valid`. The commands are RESET (0), REQUEST (1), RELEASE (2), RUN (3), RESTART (4) and MCYCLE (5). Codes 6 and 7 are unused. Some commands take more than one cycle: they wait for the acknowledge, time a reset pulse, or release bus-request for a short gap so that the host can run one machine cycle. During those commands `busy` is high. The block performs no memory cycles itself. A separate memory-cycle engine uses the bus while this block reports ownership.

The reported `state` uses bit 0 for "bus owned" and bit 1 for "host running". The reset pulse length and the bus-request release gap are parameters counted in clock cycles.

Top module: `bus_takeover_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `state` is 0, `cpu_reset_n` is low, `bus_req_n` is high, `addr_oe`, `strobe_oe` and `strobe_val` are low, and `busy` is low.
- R2: RESET (code 0) is accepted in any state while idle. It floats the address and strobes, drives `cpu_reset_n` low and `bus_req_n` high, and enters state 0.
- R3: REQUEST (code 1) in state 0 drives `bus_req_n` low and `cpu_reset_n` high. It then holds `busy` until the synchronized `bus_ack_n` is low, enables the drivers, and enters state 1.
- R4: REQUEST in state 2 drives `bus_req_n` low, waits for the acknowledge, enables the drivers and enters state 3. `cpu_reset_n` stays high throughout.
- R5: RELEASE (code 2) in state 1 floats the bus, drives `cpu_reset_n` low and `bus_req_n` high, and enters state 0. In state 3 it floats the bus, drives `bus_req_n` high and enters state 2.
- R6: RUN (code 3) in state 0 drives `cpu_reset_n` high and enters state 2. In state 1 it floats the bus and holds `cpu_reset_n` low for exactly PULSE_CYC cycles. It then enables the drivers again and enters state 3.
- R7: RESTART (code 4) in state 2 or 3 holds `cpu_reset_n` low for exactly PULSE_CYC cycles and then leaves the state unchanged. In state 3 the drivers stay enabled.
- R8: MCYCLE (code 5) in state 3 floats the bus and holds `bus_req_n` high for exactly GAP_CYC cycles. It then lowers `bus_req_n`, waits for the acknowledge, enables the drivers again, and remains in state 3.
- R9: Whenever the drivers turn on, `strobe_val` (the inactive-high strobe level) is high for exactly one cycle before `addr_oe` and `strobe_oe` rise together. While the bus floats, `strobe_val` is low.
- R10: A command not listed for the current state, or code 6 or 7, changes no output and no state.
- R11: A command presented while `busy` is high is ignored. The running operation finishes as if the command had not been presented.
- R12: While idle, `state[0]` equals `strobe_oe`, and `bus_req_n` is high whenever `state[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd | input | 3 | Command code |
| bus_ack_n | input | 1 | Host bus acknowledge, active low, asynchronous |
| cpu_reset_n | output | 1 | Host reset, active low |
| bus_req_n | output | 1 | Host bus request, active low |
| addr_oe | output | 1 | Address driver enable |
| strobe_oe | output | 1 | Read/write/memory-request strobe driver enable |
| strobe_val | output | 1 | Level presented on the strobes when driven |
| state | output | 2 | Bit 0 bus owned, bit 1 host running |
| busy | output | 1 | Multi-cycle command in progress |

## Verification
The bench varies the acknowledge delay from zero to several cycles. A design that enabled the drivers before the acknowledge, or that hung on a zero-delay acknowledge, would show the wrong state or a stuck busy. It counts the reset-low and request-high cycles in RUN from state 1, RESTART and MCYCLE, so a pulse or gap that is one cycle short or long is caught. It injects commands while busy and sends commands outside their legal states, so a design that aborted or redirected an operation would end in the wrong state. It also checks that the strobe level leads the driver enable by one cycle, which catches a design that turned on the drivers with the strobes low.

// File: rtl/bto_pkg.sv
package bto_pkg;
  localparam logic [2:0] CMD_RESET   = 3'd0;
  localparam logic [2:0] CMD_REQUEST = 3'd1;
  localparam logic [2:0] CMD_RELEASE = 3'd2;
  localparam logic [2:0] CMD_RUN     = 3'd3;
  localparam logic [2:0] CMD_RESTART = 3'd4;
  localparam logic [2:0] CMD_MCYCLE  = 3'd5;

  // bit 0: bus owned, bit 1: host running
  localparam logic [1:0] ST_HELD     = 2'd0;
  localparam logic [1:0] ST_HELD_OWN = 2'd1;
  localparam logic [1:0] ST_RUN      = 2'd2;
  localparam logic [1:0] ST_RUN_OWN  = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT_ACK,
    PH_PRE_EN,
    PH_PULSE,
    PH_GAP
  } phase_e;
endpackage

// File: rtl/bto_sync.sv
module bto_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/bto_timer.sv
module bto_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/bus_takeover_ctrl.sv
module bus_takeover_ctrl
  import bto_pkg::*;
#(
  parameter int PULSE_CYC   = 500,
  parameter int GAP_CYC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd,
  input  logic       bus_ack_n,
  output logic       cpu_reset_n,
  output logic       bus_req_n,
  output logic       addr_oe,
  output logic       strobe_oe,
  output logic       strobe_val,
  output logic [1:0] state,
  output logic       busy
);
  localparam int CNT_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYC - 1);

  phase_e        phase;
  logic [1:0]    tgt;
  logic          reenable;
  logic          ack_s;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          accept;

  bto_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (bus_ack_n), .dout (ack_s)
  );

  bto_timer #(.CW(CW)) u_timer (
    .clk (clk), .rst (rst), .load (tmr_load), .load_val (tmr_val), .done (tmr_done)
  );

  assign busy   = (phase != PH_IDLE);
  assign accept = cmd_valid && (phase == PH_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      if ((cmd == CMD_RUN && state == ST_HELD_OWN) ||
          (cmd == CMD_RESTART && state[1])) begin
        tmr_load = 1'b1;
        tmr_val  = PULSE_LD;
      end else if (cmd == CMD_MCYCLE && state == ST_RUN_OWN) begin
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      state       <= ST_HELD;
      tgt         <= ST_HELD;
      reenable    <= 1'b0;
      cpu_reset_n <= 1'b0;
      bus_req_n   <= 1'b1;
      addr_oe     <= 1'b0;
      strobe_oe   <= 1'b0;
      strobe_val  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (cmd_valid) begin
            case (cmd)
              CMD_RESET: begin
                addr_oe <= 1'b0; strobe_oe <= 1'b0; strobe_val <= 1'b0;
                cpu_reset_n <= 1'b0;
                bus_req_n   <= 1'b1;
                state       <= ST_HELD;
              end
              CMD_REQUEST: begin
                if (state == ST_HELD) begin
                  bus_req_n   <= 1'b0;
                  cpu_reset_n <= 1'b1;
                  tgt         <= ST_HELD_OWN;
                  phase       <= PH_WAIT_ACK;
                end else if (state == ST_RUN) begin
                  bus_req_n <= 1'b0;
                  tgt       <= ST_RUN_OWN;
                  phase     <= PH_WAIT_ACK;
                end
              end
              CMD_RELEASE: begin
                if (state == ST_HELD_OWN) begin
                  addr_oe <= 1'b0; strobe_oe <= 1'b0; strobe_val <= 1'b0;
                  cpu_reset_n <= 1'b0;
                  bus_req_n   <= 1'b1;
                  state       <= ST_HELD;
                end else if (state == ST_RUN_OWN) begin
                  addr_oe <= 1'b0; strobe_oe <= 1'b0; strobe_val <= 1'b0;
                  bus_req_n <= 1'b1;
                  state     <= ST_RUN;
                end
              end
              CMD_RUN: begin
                if (state == ST_HELD) begin
                  cpu_reset_n <= 1'b1;
                  state       <= ST_RUN;
                end else if (state == ST_HELD_OWN) begin
                  addr_oe <= 1'b0; strobe_oe <= 1'b0; strobe_val <= 1'b0;
                  cpu_reset_n <= 1'b0;
                  reenable    <= 1'b1;
                  tgt         <= ST_RUN_OWN;
                  phase       <= PH_PULSE;
                end
              end
              CMD_RESTART: begin
                if (state[1]) begin
                  cpu_reset_n <= 1'b0;
                  reenable    <= 1'b0;
                  phase       <= PH_PULSE;
                end
              end
              CMD_MCYCLE: begin
                if (state == ST_RUN_OWN) begin
                  addr_oe <= 1'b0; strobe_oe <= 1'b0; strobe_val <= 1'b0;
                  bus_req_n <= 1'b1;
                  tgt       <= ST_RUN_OWN;
                  phase     <= PH_GAP;
                end
              end
              default: ;
            endcase
          end
        end
        PH_WAIT_ACK: begin
          if (!ack_s) begin
            strobe_val <= 1'b1;
            phase      <= PH_PRE_EN;
          end
        end
        PH_PRE_EN: begin
          addr_oe   <= 1'b1;
          strobe_oe <= 1'b1;
          state     <= tgt;
          phase     <= PH_IDLE;
        end
        PH_PULSE: begin
          if (tmr_done) begin
            cpu_reset_n <= 1'b1;
            if (reenable) begin
              strobe_val <= 1'b1;
              phase      <= PH_PRE_EN;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_GAP: begin
          if (tmr_done) begin
            bus_req_n <= 1'b0;
            phase     <= PH_WAIT_ACK;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bto_checker.sv
module bto_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [1:0] state,
  input logic       cpu_reset_n,
  input logic       bus_req_n,
  input logic       addr_oe,
  input logic       strobe_oe,
  input logic       strobe_val
);
  AST_STROBE_LEADS: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_oe) |-> $past(strobe_val)); // R9
  AST_OE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    addr_oe == strobe_oe); // R9
  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    addr_oe |-> !bus_req_n); // R8
  AST_OWN_BIT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (strobe_oe == state[0])); // R12
  AST_REQ_OFF_UNOWNED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !state[0]) |-> bus_req_n); // R12
  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    (!busy && state == 2'd0) |-> !cpu_reset_n); // R2
  AST_RUNNING_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst)
    (!busy && state[1]) |-> cpu_reset_n); // R6
endmodule

bind bus_takeover_ctrl bto_checker u_chk (
  .clk (clk), .rst (rst), .busy (busy), .state (state),
  .cpu_reset_n (cpu_reset_n), .bus_req_n (bus_req_n),
  .addr_oe (addr_oe), .strobe_oe (strobe_oe), .strobe_val (strobe_val)
);

// File: tb/tb_bus_takeover_ctrl.sv
module tb_bus_takeover_ctrl;
  localparam int P = 40;
  localparam int G = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic bus_ack_n;
  logic cpu_reset_n, bus_req_n, addr_oe, strobe_oe, strobe_val, busy;
  logic [1:0] state;

  int total = 0;
  int bad = 0;
  int ack_dly = 2;
  bit finished = 0;
  logic [7:0] bq_hist = 8'hFF;

  // exp model
  logic [1:0] e_st = 2'd0;
  logic e_rn = 1'b0, e_bq = 1'b1, e_oe = 1'b0;

  always #10 clk = ~clk;

  bus_takeover_ctrl #(.PULSE_CYC(P), .GAP_CYC(G), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .bus_ack_n(bus_ack_n),
    .cpu_reset_n(cpu_reset_n), .bus_req_n(bus_req_n), .addr_oe(addr_oe),
    .strobe_oe(strobe_oe), .strobe_val(strobe_val), .state(state), .busy(busy)
  );

  always @(posedge clk) bq_hist <= {bq_hist[6:0], bus_req_n};
  assign bus_ack_n = (ack_dly == 0) ? bus_req_n : bq_hist[ack_dly-1];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_cmd(input logic [2:0] c, input string tag,
                        input bit intrude, input logic [2:0] ic);
    int e_pulse, e_gap, e_pre, nr, ng, np, cyc;
    e_pulse = 0; e_gap = 0; e_pre = 0;
    case (c)
      3'd0: begin e_st = 0; e_rn = 0; e_bq = 1; e_oe = 0; end
      3'd1: if (e_st == 0) begin e_st = 1; e_rn = 1; e_bq = 0; e_oe = 1; e_pre = 1; end
            else if (e_st == 2) begin e_st = 3; e_bq = 0; e_oe = 1; e_pre = 1; end
      3'd2: if (e_st == 1) begin e_st = 0; e_rn = 0; e_bq = 1; e_oe = 0; end
            else if (e_st == 3) begin e_st = 2; e_bq = 1; e_oe = 0; end
      3'd3: if (e_st == 0) begin e_st = 2; e_rn = 1; end
            else if (e_st == 1) begin e_st = 3; e_rn = 1; e_oe = 1; e_pulse = P; e_pre = 1; end
      3'd4: if (e_st[1]) begin e_pulse = P; if (e_st == 2) e_gap = P; end
      3'd5: if (e_st == 3) begin e_gap = G; e_pre = 1; end
      default: ;
    endcase
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0;
    nr = 0; ng = 0; np = 0; cyc = 0;
    while (busy && cyc < 3000) begin
      if (!cpu_reset_n) nr++;
      if (bus_req_n) ng++;
      if (strobe_val && !strobe_oe) np++;
      if (intrude && cyc == 0) begin cmd_valid = 1'b1; cmd = ic; end
      @(negedge clk);
      if (intrude && cyc == 0) cmd_valid = 1'b0;
      cyc++;
    end
    chk(tag, "not hung", int'(cyc < 3000), 1);
    chk(tag, "state", int'(state), int'(e_st));
    chk(tag, "cpu_reset_n", int'(cpu_reset_n), int'(e_rn));
    chk(tag, "bus_req_n", int'(bus_req_n), int'(e_bq));
    chk(tag, "addr_oe", int'(addr_oe), int'(e_oe));
    chk(tag, "strobe_oe", int'(strobe_oe), int'(e_oe));
    chk("R9", "strobe_val", int'(strobe_val), int'(e_oe));
    chk("R9", "lead cycles", np, e_pre);
    chk(tag, "reset pulse cycles", nr, e_pulse);
    chk(tag, "request high cycles", ng, e_gap);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "state", int'(state), 0);
    chk("R1", "cpu_reset_n", int'(cpu_reset_n), 0);
    chk("R1", "bus_req_n", int'(bus_req_n), 1);
    chk("R1", "oe", int'(addr_oe | strobe_oe | strobe_val), 0);
    chk("R1", "busy", int'(busy), 0);

    do_cmd(3'd3, "R6", 0, 3'd0);   // run 0->2
    do_cmd(3'd1, "R4", 0, 3'd0);   // request 2->3
    do_cmd(3'd4, "R7", 0, 3'd0);   // restart in 3
    ack_dly = 5;
    do_cmd(3'd5, "R8", 0, 3'd0);   // m-cycle
    ack_dly = 0;
    do_cmd(3'd5, "R8", 0, 3'd0);   // m-cycle, immediate ack
    do_cmd(3'd2, "R5", 0, 3'd0);   // release 3->2
    do_cmd(3'd4, "R7", 0, 3'd0);   // restart in 2
    do_cmd(3'd2, "R10", 0, 3'd0);  // release in 2 ignored
    do_cmd(3'd5, "R10", 0, 3'd0);  // m-cycle in 2 ignored
    ack_dly = 3;
    do_cmd(3'd1, "R4", 0, 3'd0);
    do_cmd(3'd0, "R2", 0, 3'd0);   // reset from 3
    do_cmd(3'd1, "R3", 0, 3'd0);   // request 0->1
    do_cmd(3'd4, "R10", 0, 3'd0);  // restart in 1 ignored
    do_cmd(3'd5, "R10", 0, 3'd0);
    do_cmd(3'd6, "R10", 0, 3'd0);
    do_cmd(3'd7, "R10", 0, 3'd0);
    do_cmd(3'd3, "R6", 0, 3'd0);   // run 1->3
    do_cmd(3'd0, "R2", 0, 3'd0);
    do_cmd(3'd1, "R3", 0, 3'd0);
    do_cmd(3'd2, "R5", 0, 3'd0);   // release 1->0
    do_cmd(3'd3, "R6", 0, 3'd0);
    do_cmd(3'd4, "R11", 1, 3'd0);  // reset during pulse ignored
    ack_dly = 7;
    do_cmd(3'd1, "R11", 1, 3'd2);  // release during ack wait ignored
    do_cmd(3'd5, "R11", 1, 3'd0);  // reset during gap ignored

    for (int i = 0; i < 150; i++) begin
      ack_dly = int'($urandom % 7);
      do_cmd(3'($urandom % 8), "R12", 0, 3'd0);
    end
    finish_run();
  end
endmodule